// File: doc/BRIEF.md
# Hash Accelerator Control Front-End

This block is the register and sequencing shell around an external SHA-1/SHA-256 compression core. Software programs it over a simple 32-bit register bus. The bus has a byte address, a write strobe, a read strobe, write data and registered read data. Through that bus software chooses an algorithm, an initial state, a key bank and a word source, then arms the engine with a start bit that stays set until reset.

On start, the eight state words are loaded in one of two ways. They take the built-in SHA-1 or SHA-256 initial values, or they take eight software-written initial words. After start, message words come from one of two sources. In single-word mode each CPU write to the data port supplies one word. In fetch mode the block walks a word-aligned address range through a read-request port. Each word can be byte-swapped, and it is then held in a one-deep output slot until the core accepts it.

The core can write back its resulting state. Software can read that state, and it also appears on a wide output. A length check, the slot status and a sticky alignment fault are reported in a status word.

Top module: `hash_frontend`

## Requirements
- R1: After reset the status word (offset 0x08) reads with these bits: bit0 hash-ready = 1, bit1 fetch-done = 1, bit3 record-ready = 1, bits 5:4 error = 00 and bit6 length-error = 0. Bit2 message-ready equals `core_ready`. The control word (0x0C) and the state words (0x30 + 4·i) read 0.
- R2: Writing a word with bit1 set to offset 0x10 arms the engine. After that, hash-ready reads 0, and offset 0x10 reads 0x2 until reset, whatever is written to it later.
- R3: On arming with control bit6 = 0, state words 0..7 take the SHA-1 initial values when control bits 2:1 are 0, with words 5..7 set to zero. For any other value of bits 2:1 they take the SHA-256 initial values.
- R4: On arming with control bit6 = 1, state word i takes the initial-value register at 0x90 + 4·i. These registers read back what was written.
- R5: In single-word mode (control bit0 = 1), each write to 0x1C after arming hands exactly one word to the core. A data write made before arming, or made while a word is still waiting in the slot, is dropped. Record-ready (status bit3) reads 0 while a word waits and 1 once the core has taken it.
- R6: With control bit5 = 1 every word reaching the core is byte-reversed: 0x11223344 becomes 0x44332211. With control bit5 = 0 the word passes unchanged.
- R7: While `core_valid` is high and `core_ready` is low, `core_valid` stays high and `core_data` does not change.
- R8: In fetch mode (control bit0 = 0), a fetch run starts either when the engine is armed or when 0x18 is written after arming. The run reads the byte length in 0x18 from the address in 0x14, one word per accepted request, and adds 4 to the address after each one. Fetch-done (status bit1) reads 0 while bytes remain and 1 when the count reaches zero.
- R9: A write of a value whose two low bits are not both zero to 0x14 or 0x18 sets error = 01 in status bits 5:4 until reset. While that fault is set, no fetch requests are issued, no words are handed to the core, and message-ready reads 0.
- R10: Length-error (status bit6) reads 1 exactly when the record length at 0x20 is larger than the total length at 0x24.
- R11: `core_key` is zero when control bit3 = 0. When bit3 = 1, control bit4 = 1 selects the CPU key words at 0x70..0x7C and bit4 = 0 selects the second bank at 0x80..0x8C. Key word k sits at bits 32·k+31:32·k, and every key register reads as zero.
- R12: A cycle with `res_valid` high after arming copies `res_state` into the state words. Word i is taken from bits 32·i+31:32·i, and the copy shows both on the bus and on `core_state`.
- R13: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata after the next edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dma_rd_valid | output | 1 | Word fetch request |
| dma_rd_addr | output | 32 | Byte address of the requested word |
| dma_rd_ready | input | 1 | Request accepted; dma_rd_data is valid in the same cycle |
| dma_rd_data | input | 32 | Fetched word |
| core_valid | output | 1 | Message word offered to the core |
| core_data | output | 32 | Message word, big-endian |
| core_ready | input | 1 | Core takes the offered word |
| core_sha2 | output | 1 | 1 selects the SHA-256 round function |
| core_hmac | output | 1 | Keyed mode enable |
| core_key | output | 128 | Selected key words |
| core_state | output | 256 | Current state words |
| res_valid | input | 1 | Core result strobe |
| res_state | input | 256 | Result state words from the core |

## Verification
The assertions assume that `core_ready` and `dma_rd_ready` are plain per-cycle acceptances and that the word in `dma_rd_data` belongs to the request accepted in that cycle. The bench meets this with a fetch responder that derives the word from the requested address in the same cycle. The checks also assume at most one bus access per cycle and no fetch restart while a request is being accepted. Every task issues one access and then idles one cycle, and no fetch length is rewritten during a run. The core acceptance pattern is produced by a free-running cycle counter, so stalls stay deterministic, and it changes only on the falling edge.

// File: rtl/hfe_pkg.sv
package hfe_pkg;

  // Word indices (byte offset / 4) of the register map.
  localparam int IX_STATUS = 2;
  localparam int IX_CTRL   = 3;
  localparam int IX_START  = 4;
  localparam int IX_DADDR  = 5;
  localparam int IX_DLEN   = 6;
  localparam int IX_DIN    = 7;
  localparam int IX_RLEN   = 8;
  localparam int IX_TLEN   = 9;
  localparam int IX_STATE0 = 12;
  localparam int IX_CKEY0  = 28;
  localparam int IX_LKEY0  = 32;
  localparam int IX_INIT0  = 36;

  // Control word, most significant field first (bit6 .. bit0).
  typedef struct packed {
    logic       set_init;
    logic       little;
    logic       key_cpu;
    logic       hmac;
    logic [1:0] alg;
    logic       single;
  } ctrl_t;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] std_iv(input logic sha2, input int idx);
    logic [31:0] v;
    v = '0;
    if (sha2) begin
      case (idx)
        0: v = 32'h6a09e667;
        1: v = 32'hbb67ae85;
        2: v = 32'h3c6ef372;
        3: v = 32'ha54ff53a;
        4: v = 32'h510e527f;
        5: v = 32'h9b05688c;
        6: v = 32'h1f83d9ab;
        7: v = 32'h5be0cd19;
        default: v = '0;
      endcase
    end else begin
      case (idx)
        0: v = 32'h67452301;
        1: v = 32'hefcdab89;
        2: v = 32'h98badcfe;
        3: v = 32'h10325476;
        4: v = 32'hc3d2e1f0;
        default: v = '0;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/hfe_state_bank.sv
module hfe_state_bank #(
  parameter int NWORDS = 8,
  parameter int WORD_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic                          use_init,
  input  logic                          sha2,
  input  logic [NWORDS-1:0][WORD_W-1:0] init_words,
  input  logic                          capture,
  input  logic [NWORDS-1:0][WORD_W-1:0] cap_words,
  output logic [NWORDS-1:0][WORD_W-1:0] state_words
);
  import hfe_pkg::*;

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    logic [WORD_W-1:0] iv_word;
    assign iv_word = WORD_W'(std_iv(sha2, i));

    always_ff @(posedge clk) begin
      if (rst) begin
        state_words[i] <= '0;
      end else if (load) begin
        state_words[i] <= use_init ? init_words[i] : iv_word;
      end else if (capture) begin
        state_words[i] <= cap_words[i];
      end
    end
  end

endmodule

// File: rtl/hfe_word_path.sv
module hfe_word_path #(
  parameter int DMA_AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              little,
  input  logic              fault,
  input  logic              data_wr,
  input  logic [31:0]       data_word,
  input  logic              launch,
  input  logic [DMA_AW-1:0] launch_base,
  input  logic [DMA_AW-1:0] launch_len,
  output logic              dma_rd_valid,
  output logic [DMA_AW-1:0] dma_rd_addr,
  input  logic              dma_rd_ready,
  input  logic [31:0]       dma_rd_data,
  output logic              core_valid,
  output logic [31:0]       core_data,
  input  logic              core_ready,
  output logic              dma_busy
);
  import hfe_pkg::*;

  localparam logic [DMA_AW-1:0] STEP = DMA_AW'(4);

  logic [DMA_AW-1:0] addr_q;
  logic [DMA_AW-1:0] remain_q;
  logic              slot_q;
  logic [31:0]       data_q;
  logic              slot_free;
  logic              dma_take;

  // The slot is refilled only when empty: no combinational path from
  // core_ready to either request output.
  assign slot_free    = !slot_q;
  assign dma_busy     = (remain_q != '0);
  assign dma_rd_valid = dma_busy && !fault && slot_free;
  assign dma_take     = dma_rd_valid && dma_rd_ready;
  assign dma_rd_addr  = addr_q;
  assign core_valid   = slot_q;
  assign core_data    = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q   <= '0;
      remain_q <= '0;
      slot_q   <= 1'b0;
      data_q   <= '0;
    end else begin
      if (slot_q && core_ready) slot_q <= 1'b0;

      if (dma_take) begin
        data_q <= little ? bswap32(dma_rd_data) : dma_rd_data;
        slot_q <= 1'b1;
      end else if (data_wr && slot_free && !fault) begin
        data_q <= little ? bswap32(data_word) : data_word;
        slot_q <= 1'b1;
      end

      if (launch) begin
        addr_q   <= launch_base;
        remain_q <= launch_len;
      end else if (dma_take) begin
        addr_q   <= addr_q + STEP;
        remain_q <= remain_q - STEP;
      end
    end
  end

endmodule

// File: rtl/hash_frontend.sv
module hash_frontend #(
  parameter int ADDR_W = 8,
  parameter int NWORDS = 8,
  parameter int KWORDS = 4,
  parameter int DMA_AW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 dma_rd_valid,
  output logic [DMA_AW-1:0]    dma_rd_addr,
  input  logic                 dma_rd_ready,
  input  logic [31:0]          dma_rd_data,
  output logic                 core_valid,
  output logic [31:0]          core_data,
  input  logic                 core_ready,
  output logic                 core_sha2,
  output logic                 core_hmac,
  output logic [KWORDS*32-1:0] core_key,
  output logic [NWORDS*32-1:0] core_state,
  input  logic                 res_valid,
  input  logic [NWORDS*32-1:0] res_state
);
  import hfe_pkg::*;

  localparam int IW = ADDR_W - 2;

  logic [IW-1:0]                widx;
  ctrl_t                        ctrl_q;
  logic                         started_q;
  logic                         fault_q;
  logic [DMA_AW-1:0]            daddr_q;
  logic [DMA_AW-1:0]            dlen_q;
  logic [31:0]                  rlen_q;
  logic [31:0]                  tlen_q;
  logic [KWORDS-1:0][31:0]      ckey_q;
  logic [KWORDS-1:0][31:0]      lkey_q;
  logic [NWORDS-1:0][31:0]      init_q;
  logic [NWORDS-1:0][31:0]      state_w;
  logic [NWORDS-1:0][31:0]      res_w;
  logic                         start_pulse;
  logic                         misalign_wr;
  logic                         dma_launch;
  logic [DMA_AW-1:0]            launch_len;
  logic                         data_wr;
  logic                         dma_busy;
  logic [31:0]                  status;
  logic [31:0]                  rd_mux;

  assign widx = bus_addr[ADDR_W-1:2];

  function automatic logic hit(input logic [IW-1:0] w, input int ix);
    return w == IW'(ix);
  endfunction

  assign start_pulse = bus_wr && hit(widx, IX_START) && bus_wdata[1] && !started_q;
  assign misalign_wr = bus_wr && (hit(widx, IX_DADDR) || hit(widx, IX_DLEN)) &&
                       (bus_wdata[1:0] != 2'b00);
  assign dma_launch  = !fault_q && !ctrl_q.single &&
                       (start_pulse ||
                        (bus_wr && hit(widx, IX_DLEN) && started_q && bus_wdata[1:0] == 2'b00));
  assign launch_len  = start_pulse ? dlen_q : DMA_AW'(bus_wdata);
  assign data_wr     = bus_wr && hit(widx, IX_DIN) && started_q && ctrl_q.single && !fault_q;

  // Register file
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      started_q <= 1'b0;
      fault_q   <= 1'b0;
      daddr_q   <= '0;
      dlen_q    <= '0;
      rlen_q    <= '0;
      tlen_q    <= '0;
      ckey_q    <= '0;
      lkey_q    <= '0;
      init_q    <= '0;
    end else begin
      if (start_pulse) started_q <= 1'b1;
      if (misalign_wr) fault_q <= 1'b1;
      if (bus_wr) begin
        if (hit(widx, IX_CTRL))  ctrl_q  <= ctrl_t'(bus_wdata[6:0]);
        if (hit(widx, IX_DADDR)) daddr_q <= DMA_AW'(bus_wdata);
        if (hit(widx, IX_DLEN))  dlen_q  <= DMA_AW'(bus_wdata);
        if (hit(widx, IX_RLEN))  rlen_q  <= bus_wdata;
        if (hit(widx, IX_TLEN))  tlen_q  <= bus_wdata;
        for (int k = 0; k < KWORDS; k++) begin
          if (hit(widx, IX_CKEY0 + k)) ckey_q[k] <= bus_wdata;
          if (hit(widx, IX_LKEY0 + k)) lkey_q[k] <= bus_wdata;
        end
        for (int i = 0; i < NWORDS; i++) begin
          if (hit(widx, IX_INIT0 + i)) init_q[i] <= bus_wdata;
        end
      end
    end
  end

  assign status = {25'b0,
                   (rlen_q > tlen_q),
                   1'b0, fault_q,
                   !core_valid,
                   core_ready && !fault_q,
                   !dma_busy,
                   !started_q};

  always_comb begin
    rd_mux = '0;
    if (hit(widx, IX_STATUS)) rd_mux = status;
    if (hit(widx, IX_CTRL))   rd_mux = {25'b0, ctrl_q};
    if (hit(widx, IX_START))  rd_mux = {30'b0, started_q, 1'b0};
    if (hit(widx, IX_DADDR))  rd_mux = 32'(daddr_q);
    if (hit(widx, IX_DLEN))   rd_mux = 32'(dlen_q);
    if (hit(widx, IX_RLEN))   rd_mux = rlen_q;
    if (hit(widx, IX_TLEN))   rd_mux = tlen_q;
    for (int i = 0; i < NWORDS; i++) begin
      if (hit(widx, IX_STATE0 + i)) rd_mux = state_w[i];
      if (hit(widx, IX_INIT0 + i))  rd_mux = init_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign core_sha2  = (ctrl_q.alg != 2'b00);
  assign core_hmac  = ctrl_q.hmac;
  assign core_key   = !ctrl_q.hmac ? '0 : (ctrl_q.key_cpu ? ckey_q : lkey_q);
  assign res_w      = res_state;
  assign core_state = state_w;

  hfe_state_bank #(.NWORDS(NWORDS), .WORD_W(32)) i_state (
    .clk        (clk),
    .rst        (rst),
    .load       (start_pulse),
    .use_init   (ctrl_q.set_init),
    .sha2       (core_sha2),
    .init_words (init_q),
    .capture    (res_valid && started_q),
    .cap_words  (res_w),
    .state_words(state_w)
  );

  hfe_word_path #(.DMA_AW(DMA_AW)) i_path (
    .clk         (clk),
    .rst         (rst),
    .little      (ctrl_q.little),
    .fault       (fault_q),
    .data_wr     (data_wr),
    .data_word   (bus_wdata),
    .launch      (dma_launch),
    .launch_base (daddr_q),
    .launch_len  (launch_len),
    .dma_rd_valid(dma_rd_valid),
    .dma_rd_addr (dma_rd_addr),
    .dma_rd_ready(dma_rd_ready),
    .dma_rd_data (dma_rd_data),
    .core_valid  (core_valid),
    .core_data   (core_data),
    .core_ready  (core_ready),
    .dma_busy    (dma_busy)
  );

endmodule

// File: rtl/hfe_checker.sv
module hfe_checker #(
  parameter int DMA_AW = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              started,
  input logic              fault,
  input logic              launch,
  input logic              core_valid,
  input logic              core_ready,
  input logic [31:0]       core_data,
  input logic              dma_rd_valid,
  input logic              dma_rd_ready,
  input logic [DMA_AW-1:0] dma_rd_addr
);

  // R2: arming is never undone
  a_r2_start_sticky: assert property (@(posedge clk) disable iff (rst)
    started |=> started);

  // R5: nothing reaches the core before arming
  a_r5_no_word_unarmed: assert property (@(posedge clk) disable iff (rst)
    !started |-> !core_valid);

  // R7: offered word held under back-pressure
  a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
    core_valid && !core_ready |=> core_valid && $stable(core_data));

  // R8: fetch address steps by one word per accepted request
  a_r8_addr_step: assert property (@(posedge clk) disable iff (rst)
    dma_rd_valid && dma_rd_ready && !launch |=>
      dma_rd_addr == $past(dma_rd_addr) + DMA_AW'(4));

  // R9: alignment fault stays latched
  a_r9_fault_sticky: assert property (@(posedge clk) disable iff (rst)
    fault |=> fault);

  // R9: no fetch requests while faulted
  a_r9_no_fetch_fault: assert property (@(posedge clk) disable iff (rst)
    fault |-> !dma_rd_valid);

endmodule

bind hash_frontend hfe_checker #(.DMA_AW(DMA_AW)) i_hfe_checker (
  .clk         (clk),
  .rst         (rst),
  .started     (started_q),
  .fault       (fault_q),
  .launch      (dma_launch),
  .core_valid  (core_valid),
  .core_ready  (core_ready),
  .core_data   (core_data),
  .dma_rd_valid(dma_rd_valid),
  .dma_rd_ready(dma_rd_ready),
  .dma_rd_addr (dma_rd_addr)
);

// File: tb/test_hash_frontend.sv
`timescale 1ns/100ps
module test_hash_frontend;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [7:0]   bus_addr = '0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         dma_rd_valid;
  logic [31:0]  dma_rd_addr;
  logic [31:0]  dma_rd_data;
  logic         core_valid;
  logic [31:0]  core_data;
  logic         core_ready;
  logic         core_sha2;
  logic         core_hmac;
  logic [127:0] core_key;
  logic [255:0] core_state;
  logic         res_valid = 1'b0;
  logic [255:0] res_state = '0;

  logic         hold_ready = 1'b1;
  logic         stall_en = 1'b0;
  int unsigned  cyc = 0;
  int           n_chk = 0;
  int           n_fail = 0;
  logic [31:0]  exp_q[$];
  string        tag_q[$];

  always #2.5 clk = ~clk;

  always @(negedge clk) cyc <= cyc + 1;
  assign core_ready   = stall_en ? ((cyc % 3) != 0) : hold_ready;
  assign dma_rd_data  = {dma_rd_addr[15:0], ~dma_rd_addr[15:0]};

  hash_frontend i_hash_frontend (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_rd_valid(dma_rd_valid), .dma_rd_addr(dma_rd_addr),
    .dma_rd_ready(1'b1), .dma_rd_data(dma_rd_data),
    .core_valid(core_valid), .core_data(core_data), .core_ready(core_ready),
    .core_sha2(core_sha2), .core_hmac(core_hmac), .core_key(core_key),
    .core_state(core_state), .res_valid(res_valid), .res_state(res_state)
  );

  function automatic logic [31:0] swp(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] fetch_word(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: sampled between the falling edge and the next rising edge
  always @(negedge clk) begin
    #1;
    if (!rst && core_valid && core_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R5: actual %h expected no word", core_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(t, core_data, e);
      end
    end
  end

  task automatic expect_word(input logic [31:0] w, input string t);
    exp_q.push_back(w);
    tag_q.push_back(t);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic wait_status(input int b, input logic v, input string t);
    logic [31:0] s;
    s = '0;
    for (int n = 0; n < 200; n++) begin
      rd(8'h08, s);
      if (s[b] == v) break;
    end
    chk(t, {31'b0, s[b]}, {31'b0, v});
  endtask

  task automatic check_queue_empty(input string t);
    repeat (6) @(negedge clk);
    chk(t, exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] sha1_iv [8];
    logic [31:0] sha256_iv [8];
    sha1_iv   = '{32'h67452301, 32'hefcdab89, 32'h98badcfe, 32'h10325476,
                  32'hc3d2e1f0, 32'h0, 32'h0, 32'h0};
    sha256_iv = '{32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                  32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

    // ---- R1 reset state
    do_reset();
    rd(8'h08, d); chk("R1 status", d, 32'h0000_000F);
    rd(8'h0C, d); chk("R1 ctrl", d, 32'h0);
    rd(8'h34, d); chk("R1 state1", d, 32'h0);

    // ---- R13 unmapped offset
    wr(8'hC0, 32'hDEAD_BEEF);
    rd(8'hC0, d); chk("R13 unmapped read", d, 32'h0);
    rd(8'h0C, d); chk("R13 ctrl untouched", d, 32'h0);

    // ---- R11 keys write-only
    wr(8'h70, 32'h1234_5678);
    rd(8'h70, d); chk("R11 key read zero", d, 32'h0);

    // ---- R5 data write before arming is dropped (monitor flags any word)
    wr(8'h0C, 32'h01);
    wr(8'h1C, 32'h5555_5555);

    // ---- R3 SHA-1 initial values, R2 sticky start
    wr(8'h10, 32'h2);
    for (int i = 0; i < 8; i++) begin
      rd(8'(8'h30 + 4*i), d); chk($sformatf("R3 sha1 word%0d", i), d, sha1_iv[i]);
    end
    rd(8'h08, d); chk("R2 hash-ready low", {31'b0, d[0]}, 32'h0);
    wr(8'h10, 32'h0);
    rd(8'h10, d); chk("R2 start stays set", d, 32'h2);

    // ---- R5 / R6 single-word path
    expect_word(32'hCAFE_F00D, "R6 big-endian pass");
    wr(8'h1C, 32'hCAFE_F00D);
    repeat (3) @(negedge clk);
    rd(8'h08, d); chk("R5 record-ready after take", {31'b0, d[3]}, 32'h1);
    wr(8'h0C, 32'h21);
    expect_word(32'h4433_2211, "R6 little-endian swap");
    wr(8'h1C, 32'h1122_3344);
    repeat (3) @(negedge clk);
    hold_ready = 1'b0;
    expect_word(32'hA0B0_C0D0, "R5 pending word");
    wr(8'h1C, 32'hD0C0_B0A0);
    rd(8'h08, d); chk("R5 record-ready low while pending", {31'b0, d[3]}, 32'h0);
    wr(8'h1C, 32'h9999_9999);
    repeat (4) @(negedge clk);
    hold_ready = 1'b1;
    wait_status(3, 1'b1, "R5 record-ready recovers");

    // ---- R7 under a stall pattern
    stall_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      wait_status(3, 1'b1, "R7 slot free");
      expect_word(swp(32'h0F00_0000 + k), "R7 stalled word order");
      wr(8'h1C, 32'h0F00_0000 + k);
    end
    check_queue_empty("R7 all stalled words delivered");
    stall_en = 1'b0;

    // ---- R12 result capture
    for (int i = 0; i < 8; i++) res_state[32*i +: 32] = 32'h1000_0000 + i;
    @(negedge clk); res_valid = 1'b1;
    @(negedge clk); res_valid = 1'b0;
    rd(8'h3C, d); chk("R12 state3 bus", d, 32'h1000_0003);
    chk("R12 core_state word5", core_state[32*5 +: 32], 32'h1000_0005);

    // ---- R10 length error
    wr(8'h20, 32'd10); wr(8'h24, 32'd5);
    rd(8'h08, d); chk("R10 record>total", {31'b0, d[6]}, 32'h1);
    wr(8'h24, 32'd10);
    rd(8'h08, d); chk("R10 record==total", {31'b0, d[6]}, 32'h0);

    // ---- R11 key selection
    for (int k = 0; k < 4; k++) begin
      wr(8'(8'h70 + 4*k), 32'hC0C0_0000 + k);
      wr(8'(8'h80 + 4*k), 32'hE0E0_0000 + k);
    end
    wr(8'h0C, 32'h19);
    @(negedge clk);
    chk("R11 cpu key word0", core_key[31:0], 32'hC0C0_0000);
    chk("R11 cpu key word3", core_key[127:96], 32'hC0C0_0003);
    wr(8'h0C, 32'h09);
    @(negedge clk);
    chk("R11 second bank word2", core_key[95:64], 32'hE0E0_0002);
    wr(8'h0C, 32'h11);
    @(negedge clk);
    chk("R11 keyed mode off", core_key[31:0] | core_key[127:96], 32'h0);
    check_queue_empty("R5 no stray words");

    // ---- R3 SHA-256 initial values
    do_reset();
    wr(8'h0C, 32'h02);
    wr(8'h10, 32'h2);
    for (int i = 0; i < 8; i++) begin
      rd(8'(8'h30 + 4*i), d); chk($sformatf("R3 sha256 word%0d", i), d, sha256_iv[i]);
    end
    chk("R3 sha2 select", {31'b0, core_sha2}, 32'h1);

    // ---- R4 programmed initial state
    do_reset();
    for (int i = 0; i < 8; i++) wr(8'(8'h90 + 4*i), 32'h0BAD_0000 + i);
    rd(8'h98, d); chk("R4 init readback", d, 32'h0BAD_0002);
    wr(8'h0C, 32'h42);
    wr(8'h10, 32'h2);
    for (int i = 0; i < 8; i++) begin
      rd(8'(8'h30 + 4*i), d); chk($sformatf("R4 init word%0d", i), d, 32'h0BAD_0000 + i);
    end

    // ---- R8 fetch mode
    do_reset();
    wr(8'h0C, 32'h00);
    wr(8'h14, 32'h100);
    wr(8'h18, 32'd16);
    for (int k = 0; k < 4; k++) expect_word(fetch_word(32'h100 + 4*k), "R8 fetch word");
    stall_en = 1'b1;
    wr(8'h10, 32'h2);
    rd(8'h08, d); chk("R8 fetch busy", {31'b0, d[1]}, 32'h0);
    wait_status(1, 1'b1, "R8 fetch done");
    check_queue_empty("R8 run one delivered");
    wr(8'h0C, 32'h20);
    wr(8'h14, 32'h200);
    for (int k = 0; k < 2; k++) expect_word(swp(fetch_word(32'h200 + 4*k)), "R8 relaunch swapped");
    wr(8'h18, 32'd8);
    wait_status(1, 1'b1, "R8 relaunch done");
    check_queue_empty("R8 run two delivered");
    stall_en = 1'b0;

    // ---- R9 misaligned address fault
    do_reset();
    wr(8'h0C, 32'h00);
    wr(8'h14, 32'h102);
    rd(8'h08, d);
    chk("R9 error field", {30'b0, d[5:4]}, 32'h1);
    chk("R9 message-ready low", {31'b0, d[2]}, 32'h0);
    wr(8'h14, 32'h100);
    wr(8'h18, 32'd8);
    wr(8'h10, 32'h2);
    begin
      automatic int seen = 0;
      for (int n = 0; n < 20; n++) begin
        @(negedge clk);
        if (dma_rd_valid || core_valid) seen++;
      end
      chk("R9 no fetch while faulted", seen, 0);
    end
    rd(8'h08, d); chk("R9 fault sticky", {30'b0, d[5:4]}, 32'h1);

    // ---- R9 misaligned length fault
    do_reset();
    wr(8'h18, 32'd6);
    rd(8'h08, d); chk("R9 length fault", {30'b0, d[5:4]}, 32'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule